// File: doc/BRIEF.md
# Ethernet Statistics Counter Bank

This block keeps the transmit and receive statistics of an Ethernet MAC. The MAC reports each finished frame as one status strobe per direction. Each strobe carries the frame's byte count, its address class and its error and type flags. The bank turns every strobe into increments across a fixed set of wide counters. These cover traffic totals, error tallies, short and long frame classes, and a seven-bin frame-size histogram. The parsing and CRC checking are already done upstream; the bank only consumes the classified status.

Software-facing logic reads the bank through a narrow word port. Each counter is two words wide, and the upper word is read first. That upper read snapshots the lower half into a shadow register, so the lower read that follows matches the same instant. A level-sensitive clear input zeroes everything.

Both strobe inputs are valid-only: the bank takes one frame per direction in every cycle and never applies back-pressure, so the strobe source needs no ready signal. Transmit and receive strobes may arrive in the same cycle.

Top module: `stat_counter_bank`

## Requirements
- R1: After reset every counter and the shadow register read as zero.
- R2: Transmit strobe handling:
  - Every transmit strobe adds its byte count to tx_octets (index 1).
  - With tx_err set, the strobe increments only tx_err (5), besides the octets.
  - Otherwise it increments tx_good (0), plus the class counter chosen by tx_class (00 unicast→2, 01 multicast→3, 10 broadcast→4, 11 none).
  - tx_pause adds to 6 and tx_vlan adds to 7, on good frames only.
- R3: Receive frame counting:
  - Every receive strobe adds its byte count to rx_octets (9).
  - A receive frame is bad when any of these holds: CRC error, alignment error, length error, length below 64, or length above MAX_LEN.
  - A bad frame increments rx_err (13).
  - A frame that is neither bad nor dropped increments rx_good (8).
  - Such a frame also increments its class counter (10 unicast, 11 multicast, 12 broadcast, same class encoding as R2), plus rx_pause (18) and rx_vlan (19) when flagged.
- R4: Receive error tallies:
  - rx_crc (14), rx_align (15), rx_lenerr (17) and rx_drop (20) each count their own input flag, independently of the other flags.
  - rx_toolong (16) counts frames longer than MAX_LEN.
- R5: A receive frame shorter than 64 bytes counts as undersize (21) when its CRC is good and as a fragment (24) when its CRC is bad, never both.
- R6: A receive frame longer than MAX_LEN counts as oversize (22) when its CRC is good and as a jabber (23) when its CRC is bad, never both.
- R7: Every receive frame whose length lies from 64 to MAX_LEN increments exactly one size bin, whatever its flags: 64→25, 65–127→26, 128–255→27, 256–511→28, 512–1023→29, 1024–1518→30, 1519–MAX_LEN→31.
- R8: Read addressing and timing:
  - A read with rd_en presents rd_data and rd_valid one cycle later.
  - The address is {counter index, word select}, so counter k sits at word addresses 2k and 2k+1.
  - Word select 0 returns the upper half and 1 the lower half.
- R9: An upper-word read copies the same counter's lower half into the shadow register. Every lower-word read returns the shadow, so the pair stays coherent even if the counter changes between the two reads.
- R10: While stat_clr is high, all counters and the shadow register go to zero, and a strobe in the same cycle is discarded. Counting resumes on the next strobe after stat_clr falls.
- R11: Counters wrap modulo 2^(2·WORD_W) without saturating.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stat_clr | input | 1 | Clear all counters (level) |
| tx_valid | input | 1 | Transmit frame status strobe |
| tx_len | input | LEN_W | Transmit frame byte count |
| tx_err | input | 1 | Transmit frame errored |
| tx_class | input | 2 | Transmit address class |
| tx_pause | input | 1 | Transmit frame was a pause frame |
| tx_vlan | input | 1 | Transmit frame carried a VLAN tag |
| rx_valid | input | 1 | Receive frame status strobe |
| rx_len | input | LEN_W | Receive frame byte count |
| rx_crc_err | input | 1 | Receive CRC error |
| rx_align_err | input | 1 | Receive alignment error |
| rx_len_err | input | 1 | Receive in-range length error |
| rx_drop | input | 1 | Receive frame dropped |
| rx_class | input | 2 | Receive address class |
| rx_pause | input | 1 | Receive frame was a pause frame |
| rx_vlan | input | 1 | Receive frame carried a VLAN tag |
| rd_en | input | 1 | Read request |
| rd_addr | input | $clog2(NUM_CNT)+1 | Read word address |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | WORD_W | Read data word |

## Verification
The bench builds the bank with WORD_W = 8, which gives 16-bit counters, together with MAX_LEN = 1536 and LEN_W = 14. The narrow counters put the modulo wrap within reach: 44 frames of 1500 bytes overflow the receive octet counter. They also make the upper and lower words differ in a visible way, so a coherence break shows up in a single read pair. A MAX_LEN just above 1518 keeps the top size bin, and the oversize and jabber paths, within a few frames of each other.

// File: rtl/stat_bank_pkg.sv
package stat_bank_pkg;
  localparam int NUM_CNT = 32;

  localparam int IX_TX_GOOD   = 0;
  localparam int IX_TX_OCT    = 1;
  localparam int IX_TX_UNI    = 2;
  localparam int IX_TX_MULTI  = 3;
  localparam int IX_TX_BCAST  = 4;
  localparam int IX_TX_ERR    = 5;
  localparam int IX_TX_PAUSE  = 6;
  localparam int IX_TX_VLAN   = 7;
  localparam int IX_RX_GOOD   = 8;
  localparam int IX_RX_OCT    = 9;
  localparam int IX_RX_UNI    = 10;
  localparam int IX_RX_MULTI  = 11;
  localparam int IX_RX_BCAST  = 12;
  localparam int IX_RX_ERR    = 13;
  localparam int IX_RX_CRC    = 14;
  localparam int IX_RX_ALIGN  = 15;
  localparam int IX_RX_LONG   = 16;
  localparam int IX_RX_LENERR = 17;
  localparam int IX_RX_PAUSE  = 18;
  localparam int IX_RX_VLAN   = 19;
  localparam int IX_RX_DROP   = 20;
  localparam int IX_RX_UNDER  = 21;
  localparam int IX_RX_OVER   = 22;
  localparam int IX_RX_JABBER = 23;
  localparam int IX_RX_FRAG   = 24;
  localparam int IX_BIN_FIRST = 25;
  localparam int NUM_BINS     = 7;

  localparam int MIN_FRAME = 64;

  typedef enum logic [1:0] {
    CLS_UNI   = 2'd0,
    CLS_MULTI = 2'd1,
    CLS_BCAST = 2'd2,
    CLS_NONE  = 2'd3
  } addr_class_e;
endpackage

// File: rtl/stat_event_decode.sv
module stat_event_decode
  import stat_bank_pkg::*;
#(
  parameter int LEN_W   = 14,
  parameter int MAX_LEN = 1536
) (
  input  logic                              tx_valid,
  input  logic [LEN_W-1:0]                  tx_len,
  input  logic                              tx_err,
  input  logic [1:0]                        tx_class,
  input  logic                              tx_pause,
  input  logic                              tx_vlan,
  input  logic                              rx_valid,
  input  logic [LEN_W-1:0]                  rx_len,
  input  logic                              rx_crc_err,
  input  logic                              rx_align_err,
  input  logic                              rx_len_err,
  input  logic                              rx_drop,
  input  logic [1:0]                        rx_class,
  input  logic                              rx_pause,
  input  logic                              rx_vlan,
  output logic [NUM_CNT-1:0][LEN_W-1:0]     step
);
  localparam logic [LEN_W-1:0] ONE   = LEN_W'(1);
  localparam logic [LEN_W-1:0] MAXL  = LEN_W'(MAX_LEN);
  localparam logic [LEN_W-1:0] MINL  = LEN_W'(MIN_FRAME);

  // inclusive upper edge of each size bin
  function automatic logic [LEN_W-1:0] bin_top(input int b);
    case (b)
      0:       return LEN_W'(64);
      1:       return LEN_W'(127);
      2:       return LEN_W'(255);
      3:       return LEN_W'(511);
      4:       return LEN_W'(1023);
      5:       return LEN_W'(1518);
      default: return MAXL;
    endcase
  endfunction

  logic rx_short, rx_long, rx_bad;
  logic [NUM_BINS-1:0] bin_hit;

  assign rx_short = rx_len < MINL;
  assign rx_long  = rx_len > MAXL;
  assign rx_bad   = rx_crc_err | rx_align_err | rx_len_err | rx_short | rx_long;

  // one-hot bin select: first bin whose top edge covers the length
  genvar gb;
  generate
    for (gb = 0; gb < NUM_BINS; gb++) begin : g_bin
      if (gb == 0) begin : g_first
        assign bin_hit[gb] = !rx_short && (rx_len <= bin_top(gb));
      end else begin : g_rest
        assign bin_hit[gb] = (rx_len > bin_top(gb-1)) && (rx_len <= bin_top(gb));
      end
    end
  endgenerate

  always_comb begin
    step = '0;
    if (tx_valid) begin
      step[IX_TX_OCT] = tx_len;
      if (tx_err) begin
        step[IX_TX_ERR] = ONE;
      end else begin
        step[IX_TX_GOOD] = ONE;
        case (addr_class_e'(tx_class))
          CLS_UNI:   step[IX_TX_UNI]   = ONE;
          CLS_MULTI: step[IX_TX_MULTI] = ONE;
          CLS_BCAST: step[IX_TX_BCAST] = ONE;
          default:   ;
        endcase
        if (tx_pause) step[IX_TX_PAUSE] = ONE;
        if (tx_vlan)  step[IX_TX_VLAN]  = ONE;
      end
    end
    if (rx_valid) begin
      step[IX_RX_OCT] = rx_len;
      if (rx_crc_err)   step[IX_RX_CRC]    = ONE;
      if (rx_align_err) step[IX_RX_ALIGN]  = ONE;
      if (rx_len_err)   step[IX_RX_LENERR] = ONE;
      if (rx_drop)      step[IX_RX_DROP]   = ONE;
      if (rx_short) begin
        if (rx_crc_err) step[IX_RX_FRAG]  = ONE;
        else            step[IX_RX_UNDER] = ONE;
      end
      if (rx_long) begin
        step[IX_RX_LONG] = ONE;
        if (rx_crc_err) step[IX_RX_JABBER] = ONE;
        else            step[IX_RX_OVER]   = ONE;
      end
      if (rx_bad) begin
        step[IX_RX_ERR] = ONE;
      end else if (!rx_drop) begin
        step[IX_RX_GOOD] = ONE;
        case (addr_class_e'(rx_class))
          CLS_UNI:   step[IX_RX_UNI]   = ONE;
          CLS_MULTI: step[IX_RX_MULTI] = ONE;
          CLS_BCAST: step[IX_RX_BCAST] = ONE;
          default:   ;
        endcase
        if (rx_pause) step[IX_RX_PAUSE] = ONE;
        if (rx_vlan)  step[IX_RX_VLAN]  = ONE;
      end
      for (int b = 0; b < NUM_BINS; b++) begin
        if (bin_hit[b]) step[IX_BIN_FIRST + b] = ONE;
      end
    end
  end
endmodule

// File: rtl/stat_counter.sv
module stat_counter #(
  parameter int CNT_W  = 64,
  parameter int STEP_W = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic [STEP_W-1:0] step,
  output logic [CNT_W-1:0]  q
);
  // clear wins over any step; sum wraps modulo 2^CNT_W
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= '0;
    else if (clr) q <= '0;
    else          q <= q + CNT_W'(step);
  end
endmodule

// File: rtl/stat_readout.sv
module stat_readout #(
  parameter int NCNT   = 32,
  parameter int WORD_W = 32,
  parameter int ADDR_W = 6
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             clr,
  input  logic                             rd_en,
  input  logic [ADDR_W-1:0]                rd_addr,
  input  logic [NCNT-1:0][2*WORD_W-1:0]    cnt,
  output logic                             rd_valid,
  output logic [WORD_W-1:0]                rd_data
);
  localparam int CNT_W = 2 * WORD_W;

  logic [CNT_W-1:0]  sel;
  logic [WORD_W-1:0] shadow_q;
  logic              want_lower;

  assign sel        = cnt[rd_addr[ADDR_W-1:1]];
  assign want_lower = rd_addr[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
      shadow_q <= '0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) begin
        if (want_lower) begin
          rd_data <= shadow_q;
        end else begin
          rd_data  <= sel[CNT_W-1:WORD_W];
          shadow_q <= sel[WORD_W-1:0];
        end
      end
      if (clr) shadow_q <= '0;
    end
  end
endmodule

// File: rtl/stat_counter_bank.sv
module stat_counter_bank
  import stat_bank_pkg::*;
#(
  parameter int WORD_W  = 32,
  parameter int LEN_W   = 14,
  parameter int MAX_LEN = 1536
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          stat_clr,
  input  logic                          tx_valid,
  input  logic [LEN_W-1:0]              tx_len,
  input  logic                          tx_err,
  input  logic [1:0]                    tx_class,
  input  logic                          tx_pause,
  input  logic                          tx_vlan,
  input  logic                          rx_valid,
  input  logic [LEN_W-1:0]              rx_len,
  input  logic                          rx_crc_err,
  input  logic                          rx_align_err,
  input  logic                          rx_len_err,
  input  logic                          rx_drop,
  input  logic [1:0]                    rx_class,
  input  logic                          rx_pause,
  input  logic                          rx_vlan,
  input  logic                          rd_en,
  input  logic [$clog2(NUM_CNT):0]      rd_addr,
  output logic                          rd_valid,
  output logic [WORD_W-1:0]             rd_data
);
  localparam int CNT_W  = 2 * WORD_W;
  localparam int ADDR_W = $clog2(NUM_CNT) + 1;

  logic [NUM_CNT-1:0][LEN_W-1:0] step;
  logic [NUM_CNT-1:0][CNT_W-1:0] cnt_q;

  stat_event_decode #(.LEN_W(LEN_W), .MAX_LEN(MAX_LEN)) u_decode (
    .tx_valid(tx_valid), .tx_len(tx_len), .tx_err(tx_err), .tx_class(tx_class),
    .tx_pause(tx_pause), .tx_vlan(tx_vlan),
    .rx_valid(rx_valid), .rx_len(rx_len), .rx_crc_err(rx_crc_err),
    .rx_align_err(rx_align_err), .rx_len_err(rx_len_err), .rx_drop(rx_drop),
    .rx_class(rx_class), .rx_pause(rx_pause), .rx_vlan(rx_vlan),
    .step(step)
  );

  genvar gi;
  generate
    for (gi = 0; gi < NUM_CNT; gi++) begin : g_cnt
      stat_counter #(.CNT_W(CNT_W), .STEP_W(LEN_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .clr(stat_clr), .step(step[gi]), .q(cnt_q[gi])
      );
    end
  endgenerate

  stat_readout #(.NCNT(NUM_CNT), .WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_read (
    .clk(clk), .rst_n(rst_n), .clr(stat_clr), .rd_en(rd_en), .rd_addr(rd_addr),
    .cnt(cnt_q), .rd_valid(rd_valid), .rd_data(rd_data)
  );
endmodule

// File: rtl/stat_bank_checker.sv
module stat_bank_checker
  import stat_bank_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input logic                               clk,
  input logic                               rst_n,
  input logic                               stat_clr,
  input logic                               rd_en,
  input logic [$clog2(NUM_CNT):0]           rd_addr,
  input logic                               rd_valid,
  input logic [WORD_W-1:0]                  rd_data,
  input logic [NUM_CNT-1:0][2*WORD_W-1:0]   cnt
);
  localparam int CNT_W = 2 * WORD_W;

  logic [WORD_W-1:0] sel_upper;
  logic [CNT_W-1:0]  good_delta;
  logic [CNT_W-1:0]  good_prev;

  assign sel_upper = cnt[rd_addr[$clog2(NUM_CNT):1]][CNT_W-1:WORD_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) good_prev <= '0;
    else        good_prev <= cnt[IX_TX_GOOD];
  end
  assign good_delta = cnt[IX_TX_GOOD] - good_prev;

  // R10: a clear leaves every counter at zero on the next cycle
  assert_clear_zeroes_R10: assert property (@(posedge clk) disable iff (!rst_n)
    stat_clr |=> (cnt == '0));

  // R8: read data appears exactly one cycle after the request
  assert_read_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);

  assert_no_spurious_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rd_valid);

  // R8: an upper-word read returns the addressed counter's upper half
  assert_upper_word_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !rd_addr[0]) |=> (rd_data == $past(sel_upper)));

  // R2: the transmit good-frame counter advances by at most one per cycle
  assert_good_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(stat_clr) |-> (good_delta <= CNT_W'(1)));
endmodule

bind stat_counter_bank stat_bank_checker #(.WORD_W(WORD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .stat_clr(stat_clr), .rd_en(rd_en), .rd_addr(rd_addr),
  .rd_valid(rd_valid), .rd_data(rd_data), .cnt(cnt_q)
);

// File: tb/tb_stat_counter_bank.sv
module tb_stat_counter_bank;
  localparam int WORD_W  = 8;
  localparam int LEN_W   = 14;
  localparam int MAX_LEN = 1536;
  localparam int NC      = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic stat_clr = 1'b0;
  logic tx_valid = 1'b0, tx_err = 1'b0, tx_pause = 1'b0, tx_vlan = 1'b0;
  logic [LEN_W-1:0] tx_len = '0;
  logic [1:0] tx_class = 2'd0;
  logic rx_valid = 1'b0, rx_crc_err = 1'b0, rx_align_err = 1'b0, rx_len_err = 1'b0;
  logic rx_drop = 1'b0, rx_pause = 1'b0, rx_vlan = 1'b0;
  logic [LEN_W-1:0] rx_len = '0;
  logic [1:0] rx_class = 2'd0;
  logic rd_en = 1'b0;
  logic [5:0] rd_addr = '0;
  logic rd_valid;
  logic [WORD_W-1:0] rd_data;

  always #2 clk = ~clk;

  stat_counter_bank #(.WORD_W(WORD_W), .LEN_W(LEN_W), .MAX_LEN(MAX_LEN)) dut (
    .clk(clk), .rst_n(rst_n), .stat_clr(stat_clr),
    .tx_valid(tx_valid), .tx_len(tx_len), .tx_err(tx_err), .tx_class(tx_class),
    .tx_pause(tx_pause), .tx_vlan(tx_vlan),
    .rx_valid(rx_valid), .rx_len(rx_len), .rx_crc_err(rx_crc_err),
    .rx_align_err(rx_align_err), .rx_len_err(rx_len_err), .rx_drop(rx_drop),
    .rx_class(rx_class), .rx_pause(rx_pause), .rx_vlan(rx_vlan),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data)
  );

  logic [15:0] m [NC];
  logic [7:0]  sh;
  logic [7:0]  exp_q [$];
  string       tag_q [$];
  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  // monitor: pops expected words as read data appears
  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (exp_q.size() == 0) begin
        mismatched++;
        $display("FAIL R8 unexpected read data: got %0h expected none", rd_data);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        compared++;
        if (rd_data !== e) begin
          mismatched++;
          $display("FAIL %s: got %0h expected %0h", t, rd_data, e);
        end
      end
    end
  end

  task automatic push(input logic [7:0] e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
  endtask

  // upper then lower read of one counter
  task automatic read_cnt(input int idx, input string t);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = 6'(idx * 2);
    push(m[idx][15:8], $sformatf("%s cnt%0d upper", t, idx));
    sh = m[idx][7:0];
    @(negedge clk);
    rd_addr = 6'(idx * 2 + 1);
    push(sh, $sformatf("%s cnt%0d lower", t, idx));
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic tx_frame(input int len, input bit err, input logic [1:0] cls,
                          input bit pz, input bit vl);
    @(negedge clk);
    tx_valid = 1'b1; tx_len = LEN_W'(len); tx_err = err; tx_class = cls;
    tx_pause = pz; tx_vlan = vl;
    m[1] = m[1] + 16'(len);
    if (err) m[5]++;
    else begin
      m[0]++;
      if (cls == 2'd0) m[2]++;
      if (cls == 2'd1) m[3]++;
      if (cls == 2'd2) m[4]++;
      if (pz) m[6]++;
      if (vl) m[7]++;
    end
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic rx_model(input int len, input bit crc, input bit aln, input bit le,
                          input bit drp, input logic [1:0] cls, input bit pz, input bit vl);
    bit short_f, long_f, bad;
    short_f = len < 64;
    long_f  = len > MAX_LEN;
    bad = crc | aln | le | short_f | long_f;
    m[9] = m[9] + 16'(len);
    if (crc) m[14]++;
    if (aln) m[15]++;
    if (le)  m[17]++;
    if (drp) m[20]++;
    if (short_f) begin
      if (crc) m[24]++; else m[21]++;
    end
    if (long_f) begin
      m[16]++;
      if (crc) m[23]++; else m[22]++;
    end
    if (bad) m[13]++;
    else if (!drp) begin
      m[8]++;
      if (cls == 2'd0) m[10]++;
      if (cls == 2'd1) m[11]++;
      if (cls == 2'd2) m[12]++;
      if (pz) m[18]++;
      if (vl) m[19]++;
    end
    if (!short_f && !long_f) begin
      if (len == 64)        m[25]++;
      else if (len <= 127)  m[26]++;
      else if (len <= 255)  m[27]++;
      else if (len <= 511)  m[28]++;
      else if (len <= 1023) m[29]++;
      else if (len <= 1518) m[30]++;
      else                  m[31]++;
    end
  endtask

  task automatic rx_drive(input int len, input bit crc, input bit aln, input bit le,
                          input bit drp, input logic [1:0] cls, input bit pz, input bit vl);
    rx_valid = 1'b1; rx_len = LEN_W'(len); rx_crc_err = crc; rx_align_err = aln;
    rx_len_err = le; rx_drop = drp; rx_class = cls; rx_pause = pz; rx_vlan = vl;
  endtask

  task automatic rx_frame(input int len, input bit crc, input bit aln, input bit le,
                          input bit drp, input logic [1:0] cls, input bit pz, input bit vl);
    @(negedge clk);
    rx_drive(len, crc, aln, le, drp, cls, pz, vl);
    rx_model(len, crc, aln, le, drp, cls, pz, vl);
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog R8: got running expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NC; i++) m[i] = '0;
    sh = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1: reset state
    read_cnt(0, "R1");
    read_cnt(9, "R1");
    read_cnt(31, "R1");

    // R2: transmit counting
    tx_frame(100, 0, 2'd0, 0, 1);
    tx_frame(64, 0, 2'd1, 0, 0);
    tx_frame(1000, 1, 2'd2, 1, 1);
    tx_frame(200, 0, 2'd2, 1, 0);
    tx_frame(300, 0, 2'd3, 0, 0);
    for (int i = 0; i < 8; i++) read_cnt(i, "R2");

    // R3, R7: good receive frames across all size bins
    rx_frame(64, 0, 0, 0, 0, 2'd0, 0, 0);
    rx_frame(65, 0, 0, 0, 0, 2'd1, 0, 1);
    rx_frame(127, 0, 0, 0, 0, 2'd2, 1, 0);
    rx_frame(128, 0, 0, 0, 0, 2'd0, 0, 0);
    rx_frame(600, 0, 0, 0, 0, 2'd1, 0, 0);
    rx_frame(1518, 0, 0, 0, 0, 2'd0, 0, 1);
    rx_frame(1519, 0, 0, 0, 0, 2'd2, 0, 0);
    rx_frame(1536, 0, 0, 0, 0, 2'd0, 0, 0);
    rx_frame(300, 0, 0, 0, 0, 2'd3, 0, 0);
    for (int i = 8; i < 13; i++) read_cnt(i, "R3");
    read_cnt(18, "R3");
    read_cnt(19, "R3");
    for (int i = 25; i < 32; i++) read_cnt(i, "R7");

    // R4, R5, R6: error tallies and short/long classes
    rx_frame(60, 0, 0, 0, 0, 2'd0, 0, 0);
    rx_frame(40, 1, 0, 0, 0, 2'd0, 0, 0);
    rx_frame(1600, 0, 0, 0, 0, 2'd0, 0, 0);
    rx_frame(1700, 1, 0, 0, 0, 2'd0, 0, 0);
    rx_frame(300, 0, 1, 0, 0, 2'd0, 0, 0);
    rx_frame(400, 0, 0, 1, 0, 2'd1, 0, 0);
    rx_frame(500, 0, 0, 0, 1, 2'd2, 0, 0);
    rx_frame(700, 1, 1, 0, 1, 2'd0, 1, 1);
    for (int i = 13; i < 18; i++) read_cnt(i, "R4");
    read_cnt(20, "R4");
    read_cnt(21, "R5");
    read_cnt(24, "R5");
    read_cnt(22, "R6");
    read_cnt(23, "R6");
    read_cnt(8, "R4");

    // R9: shadow keeps the lower half coherent with the upper read
    @(negedge clk);
    rd_en = 1'b1; rd_addr = 6'd18;
    push(m[9][15:8], "R9 upper snapshot");
    sh = m[9][7:0];
    @(negedge clk);
    rd_en = 1'b0;
    rx_frame(100, 0, 0, 0, 0, 2'd0, 0, 0);
    rx_frame(77, 0, 0, 0, 0, 2'd0, 0, 0);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = 6'd19;
    push(sh, "R9 lower from shadow");
    @(negedge clk);
    rd_en = 1'b0;
    read_cnt(9, "R9");

    // R11: octet counter wraps modulo 2^16
    for (int i = 0; i < 44; i++) rx_frame(1500, 0, 0, 0, 0, 2'd0, 0, 0);
    read_cnt(9, "R11");
    read_cnt(8, "R11");
    read_cnt(30, "R11");

    // R10: clear wins over a same-cycle strobe, and zeroes the shadow
    @(negedge clk);
    stat_clr = 1'b1;
    rx_drive(100, 0, 0, 0, 0, 2'd0, 0, 0);
    tx_valid = 1'b1; tx_len = LEN_W'(80); tx_err = 1'b0; tx_class = 2'd0;
    @(negedge clk);
    stat_clr = 1'b0; rx_valid = 1'b0; tx_valid = 1'b0;
    for (int i = 0; i < NC; i++) m[i] = '0;
    @(negedge clk);
    rd_en = 1'b1; rd_addr = 6'd19;
    push(8'h00, "R10 shadow cleared");
    @(negedge clk);
    rd_en = 1'b0;
    read_cnt(0, "R10");
    read_cnt(1, "R10");
    read_cnt(9, "R10");
    read_cnt(26, "R10");
    rx_frame(90, 0, 0, 0, 0, 2'd1, 0, 0);
    read_cnt(8, "R10");
    read_cnt(11, "R10");

    repeat (4) @(negedge clk);
    if (exp_q.size() != 0) begin
      mismatched++;
      $display("FAIL R8 missing read data: got %0d pending expected 0", exp_q.size());
    end
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule